// File: doc/BRIEF.md
# Host Interrupt Request Generator for an SPI Ethernet MAC-PHY

This block drives the active-low interrupt line that an SPI-attached Ethernet MAC-PHY uses to call its host. It watches three conditions: receive chunks waiting to be read, free transmit credits, and a pending extended status event. When an extended event is pending, the host is expected to read status register 0 to learn its cause. Each condition is judged against the values the host last saw, not against live changes. Each time a data footer is shifted out, the block stores whether each condition was nonzero at that moment.

An interrupt is requested when a condition that the last footer showed as empty becomes present. The request holds until the first data header of the next transfer arrives. The host's next transfer already carries fresh footer information, so the header acts as the acknowledge. After that clear, no new request is made until another footer has been sent. A new footer refreshes the stored snapshot, so the request is always measured against what the host has actually seen.

Top module: `irq_gen`

## Requirements
- R1: When the stored snapshot shows no receive chunks, the block is armed and `rx_chunks` is nonzero, `irq_n` goes low on the next clock edge.
- R2: When the stored snapshot shows no transmit credits, the block is armed and `tx_credits` is nonzero, `irq_n` goes low on the next clock edge.
- R3: When the stored snapshot shows no extended status, the block is armed and `ext_pending` is 1, `irq_n` goes low on the next clock edge.
- R4: A cycle with `hdr_rcvd` high drives `irq_n` high on the next edge. This holds even if a raise condition is true in that same cycle.
- R5: A pulse on `ftr_sent` stores three flags: `rx_chunks`≠0, `tx_credits`≠0 and `ext_pending`. A condition whose stored flag is 1 does not request an interrupt.
- R6: Once low, `irq_n` stays low until `hdr_rcvd` is seen, even if the condition that raised it goes away.
- R7: After a header clear, `irq_n` stays high until an `ftr_sent` pulse re-arms the block. Conditions are evaluated against the snapshot stored before the current edge.
- R8: Reset drives `irq_n` high, clears the snapshot to all-none and arms the block. The first nonzero resource after reset therefore raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_chunks | input | RX_W | Receive chunks currently available |
| tx_credits | input | TX_W | Transmit credits currently free |
| ext_pending | input | 1 | Extended status event pending |
| ftr_sent | input | 1 | One-cycle strobe: a data footer was shifted out |
| hdr_rcvd | input | 1 | One-cycle strobe: a data header was received |
| irq_n | output | 1 | Interrupt to the host, active low, registered |

## Verification
Every result is due exactly one clock edge after the input cycle that causes it. `irq_n` is a flop fed by the raise, clear and arm logic. The snapshot and the arm state also update on that same edge, so they affect only the following cycle. The bench drives inputs on the falling edge and advances a reference model at the rising edge. It compares `irq_n` at the next falling edge. This keeps each check exactly one edge after its stimulus. Directed sequences cover the same-cycle header-and-raise case and the hold with the condition removed. They also cover the re-arm by footer.

// File: rtl/irq_gen.sv
module irq_gen #(
  parameter int RX_W = 5,
  parameter int TX_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RX_W-1:0] rx_chunks,
  input  logic [TX_W-1:0] tx_credits,
  input  logic            ext_pending,
  input  logic            ftr_sent,
  input  logic            hdr_rcvd,
  output logic            irq_n
);

  localparam int NCOND = 3;

  logic [NCOND-1:0] live, snap, fresh;
  logic armed, irq_q, raise;

  assign live  = {ext_pending, |tx_credits, |rx_chunks};
  assign fresh = live & ~snap;
  assign raise = armed & (|fresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap  <= '0;
      armed <= 1'b1;
      irq_q <= 1'b0;
    end else begin
      if (hdr_rcvd)   irq_q <= 1'b0;
      else if (raise) irq_q <= 1'b1;
      if (ftr_sent)      armed <= 1'b1;
      else if (hdr_rcvd) armed <= 1'b0;
      if (ftr_sent) snap <= live;
    end
  end

  assign irq_n = ~irq_q;

  assert_rx_raise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !snap[0] && rx_chunks != '0 && !hdr_rcvd) |=> !irq_n);
  assert_tx_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !snap[1] && tx_credits != '0 && !hdr_rcvd) |=> !irq_n);
  assert_ext_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !snap[2] && ext_pending && !hdr_rcvd) |=> !irq_n);
  assert_hdr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_rcvd |=> irq_n);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !hdr_rcvd) |=> !irq_n);
  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n && !armed && !ftr_sent) |=> irq_n);

endmodule

// File: tb/irq_gen_tb.sv
module irq_gen_tb;
  localparam int RX_W = 5, TX_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [RX_W-1:0] rx = '0;
  logic [TX_W-1:0] tx = '0;
  logic ext = 1'b0, ftr = 1'b0, hdr = 1'b0;
  logic irq_n;

  int errors = 0, checks = 0;
  logic [2:0] m_snap;
  logic m_armed, m_irq;
  bit done = 0;

  always #4 clk = ~clk;

  irq_gen #(.RX_W(RX_W), .TX_W(TX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_chunks(rx), .tx_credits(tx),
    .ext_pending(ext), .ftr_sent(ftr), .hdr_rcvd(hdr), .irq_n(irq_n));

  function automatic logic cause_of(logic [2:0] s, logic [RX_W-1:0] r,
                                    logic [TX_W-1:0] t, logic e);
    return (!s[0] && r != 0) || (!s[1] && t != 0) || (!s[2] && e);
  endfunction

  function automatic string tag_of(logic [2:0] s, logic h, logic a);
    if (h) return "R4";
    if (!a) return "R7";
    if (!s[0] && rx != 0) return "R1";
    if (!s[1] && tx != 0) return "R2";
    if (!s[2] && ext) return "R3";
    return "R5";
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: irq_n=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic [RX_W-1:0] r, logic [TX_W-1:0] t, logic e,
                      logic f, logic h, string tag = "");
    logic c;
    string tg;
    rx = r; tx = t; ext = e; ftr = f; hdr = h;
    tg = (tag == "") ? (m_irq && !h ? "R6" : tag_of(m_snap, h, m_armed)) : tag;
    @(posedge clk);
    c = cause_of(m_snap, r, t, e);
    if (h) m_irq = 0; else if (m_armed && c) m_irq = 1;
    if (f) m_armed = 1; else if (h) m_armed = 0;
    if (f) m_snap = {e, t != 0, r != 0};
    @(negedge clk);
    check(tg, irq_n, !m_irq);
  endtask

  initial begin
    m_snap = 0; m_armed = 1; m_irq = 0;
    repeat (3) @(negedge clk);
    check("R8", irq_n, 1'b1);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, "R8");
    step(3, 0, 0, 0, 0, "R1");     // first resource after reset raises
    step(0, 0, 0, 0, 0, "R6");     // condition gone, still held
    step(0, 0, 0, 0, 1, "R4");
    step(3, 0, 0, 0, 0, "R7");     // disarmed until footer
    step(3, 0, 0, 1, 0, "R5");     // footer stores rx nonzero
    step(3, 0, 0, 0, 0, "R5");
    step(3, 4, 0, 0, 0, "R2");
    step(3, 4, 0, 0, 1, "R4");
    step(0, 0, 0, 1, 0, "R7");     // footer re-arms, all none
    step(0, 0, 1, 0, 1, "R4");     // header wins over same-cycle raise
    step(0, 0, 0, 1, 0, "R7");
    step(0, 0, 1, 0, 0, "R3");
    step(0, 0, 1, 1, 1, "R4");     // footer stores ext pending
    step(0, 0, 1, 0, 0, "R5");
    $urandom(32'h1A2B);
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 3) == 0 ? RX_W'($urandom) : '0,
           $urandom_range(0, 3) == 0 ? TX_W'($urandom) : '0,
           $urandom_range(0, 4) == 0,
           $urandom_range(0, 6) == 0,
           $urandom_range(0, 6) == 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: timeout");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule